// File: doc/BRIEF.md
# Cycle-Stealing Dual-Address DMA Channel

A single DMA channel that copies a block of data between two regions of an external 16-bit memory. Every transfer unit (byte, word or longword) is moved in two phases: the channel reads all bytes of the unit from the source region, then writes them to the destination region. Each access is a 2-state bus cycle. Between units the channel releases the bus for a programmable number of idle clocks, so the processor can run its own bus cycles. It then asks for the bus again.

Software loads the source address, the destination address and the unit count through a small register write port, then writes a control word. The control word selects the unit size, enables the transfer-end flag and starts the channel. The bus is 16 bits wide with big-endian lanes. An access that is not aligned to a 16-bit word is split into byte and word accesses, so a longword at any byte address still reaches the correct bytes.

Top module: `dma_steal_chan`

## Requirements
- R1: Register writes use reg_addr_i: 0 = source address, 1 = destination address, 2 = unit count, 3 = control. In the control word, bit 0 starts the channel, bits 2:1 select the size (0 byte, 1 word, 2 longword) and bit 3 enables the transfer-end flag. Any register write made while a transfer is active is ignored.
- R2: For each unit, all read accesses of the unit's source bytes come before any write access of that unit. The destination ends with a byte-exact copy of the source.
- R3: Every access lasts two clocks with the same address in both. The read strobe or the write strobes are active in the second clock only.
- R4: A unit is covered in ascending address order. A word access is used when the address is even and at least two bytes of the unit remain; otherwise a byte access is used. Together the accesses cover exactly the unit size.
- R5: Byte lanes are big-endian. An even address uses data[15:8] and wr_hi_o; an odd address uses data[7:0] and wr_lo_o. A word access asserts both write strobes at an even address.
- R6: After each unit, both addresses advance by the unit size and the count drops by one. The channel stops after the programmed number of units. A start with a count of zero does nothing.
- R7: bus_req_o rises in the clock after the start write and stays high for the whole unit. It falls in the clock after the unit's last write strobe. No access begins until bus_gnt_i is seen high.
- R8: Once bus_req_o has dropped between units, it stays low for at least MIN_IDLE clocks before it rises again.
- R9: When enabled, tend_o is high in every access of the final unit. It is low during every other unit, and low always when the flag is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| reg_we_i | input | 1 | register write enable |
| reg_addr_i | input | 2 | register select |
| reg_wdata_i | input | 32 | register write data |
| bus_gnt_i | input | 1 | bus grant from arbiter |
| bus_req_o | output | 1 | bus request |
| addr_o | output | AW | memory byte address |
| rd_o | output | 1 | read strobe |
| wr_hi_o | output | 1 | upper byte lane write strobe |
| wr_lo_o | output | 1 | lower byte lane write strobe |
| data_i | input | 16 | read data |
| data_o | output | 16 | write data |
| tend_o | output | 1 | transfer-end flag |

## Verification
The bus request is due one clock after the start write. Strobes arrive on the second clock of each access and are sampled on the falling edge, with the address of the previous falling edge kept for comparison. The drop of the request is checked exactly one falling edge after a unit's last write strobe, and the idle gap is measured from there until the request rises again. Memory contents, access counts and the transfer-end flag are checked against values computed from the size, the two alignments and the unit count, over every combination of size and of source and destination offsets within a longword.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_RD1, S_RD2, S_WR1, S_WR2
  } dma_state_e;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_split.sv
// Picks the next access of a unit: word if even and two bytes remain.
module dma_split #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [2:0]    idx_i,
  input  logic [2:0]    nbytes_i,
  output logic [AW-1:0] addr_o,
  output logic          two_o,
  output logic [2:0]    step_o,
  output logic          last_o
);
  logic [2:0] rem;
  always_comb begin
    addr_o = base_i + AW'(idx_i);
    rem    = nbytes_i - idx_i;
    two_o  = !addr_o[0] && (rem >= 3'd2);
    step_o = two_o ? 3'd2 : 3'd1;
    last_o = (idx_i + step_o) >= nbytes_i;
  end
endmodule

// File: rtl/dma_lanes.sv
// Big-endian lane steering for write accesses.
module dma_lanes (
  input  logic       en_i,
  input  logic       odd_i,
  input  logic       two_i,
  input  logic [7:0] b0_i,
  input  logic [7:0] b1_i,
  output logic [15:0] data_o,
  output logic       hi_o,
  output logic       lo_o
);
  always_comb begin
    data_o = two_i ? {b0_i, b1_i} : {b0_i, b0_i};
    hi_o   = en_i && (two_i || !odd_i);
    lo_o   = en_i && (two_i || odd_i);
  end
endmodule

// File: rtl/dma_steal_chan.sv
module dma_steal_chan
  import dma_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int MIN_IDLE = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          bus_gnt_i,
  output logic          bus_req_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_hi_o,
  output logic          wr_lo_o,
  input  logic [15:0]   data_i,
  output logic [15:0]   data_o,
  output logic          tend_o
);
  localparam int GW = $clog2(MIN_IDLE + 1);

  dma_state_e       st_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [CW-1:0]    cnt_q;
  logic [1:0]       size_q;
  logic             tend_en_q;
  logic [2:0]       idx_q;
  logic [GW-1:0]    gap_q;
  logic [3:0][7:0]  buf_q;

  logic [2:0]    nb;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          rd_two, wr_two, rd_last, wr_last;
  logic [2:0]    rd_step, wr_step;
  logic          active, in_bus, start;
  logic [1:0]    bi0, bi1;

  assign nb     = unit_bytes(size_q);
  assign active = (st_q != S_IDLE);
  assign in_bus = (st_q == S_RD1) || (st_q == S_RD2) || (st_q == S_WR1) || (st_q == S_WR2);
  assign start  = reg_we_i && !active && (reg_addr_i == REG_CTRL) && reg_wdata_i[0];
  assign bi0    = idx_q[1:0];
  assign bi1    = idx_q[1:0] + 2'd1;

  dma_split #(.AW(AW)) u_rd_split (
    .base_i(src_q), .idx_i(idx_q), .nbytes_i(nb),
    .addr_o(rd_addr), .two_o(rd_two), .step_o(rd_step), .last_o(rd_last)
  );

  dma_split #(.AW(AW)) u_wr_split (
    .base_i(dst_q), .idx_i(idx_q), .nbytes_i(nb),
    .addr_o(wr_addr), .two_o(wr_two), .step_o(wr_step), .last_o(wr_last)
  );

  dma_lanes u_lanes (
    .en_i(st_q == S_WR2), .odd_i(wr_addr[0]), .two_i(wr_two),
    .b0_i(buf_q[bi0]), .b1_i(buf_q[bi1]),
    .data_o(data_o), .hi_o(wr_hi_o), .lo_o(wr_lo_o)
  );

  always_comb begin
    bus_req_o = in_bus || ((st_q == S_WAIT) && (gap_q == '0));
    addr_o    = ((st_q == S_WR1) || (st_q == S_WR2)) ? wr_addr : rd_addr;
    rd_o      = (st_q == S_RD2);
    tend_o    = tend_en_q && in_bus && (cnt_q == CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      size_q    <= '0;
      tend_en_q <= 1'b0;
      idx_q     <= '0;
      gap_q     <= '0;
      buf_q     <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (reg_we_i) begin
            case (reg_addr_i)
              REG_SRC: src_q <= reg_wdata_i[AW-1:0];
              REG_DST: dst_q <= reg_wdata_i[AW-1:0];
              REG_CNT: cnt_q <= reg_wdata_i[CW-1:0];
              default: begin
                size_q    <= (reg_wdata_i[2:1] == 2'd3) ? 2'd2 : reg_wdata_i[2:1];
                tend_en_q <= reg_wdata_i[3];
              end
            endcase
          end
          if (start && cnt_q != '0) begin
            st_q  <= S_WAIT;
            gap_q <= '0;
          end
        end
        S_WAIT: begin
          if (gap_q != '0) gap_q <= gap_q - GW'(1);
          else if (bus_gnt_i) begin
            st_q  <= S_RD1;
            idx_q <= '0;
          end
        end
        S_RD1: st_q <= S_RD2;
        S_RD2: begin
          if (rd_two) begin
            buf_q[bi0] <= data_i[15:8];
            buf_q[bi1] <= data_i[7:0];
          end else begin
            buf_q[bi0] <= rd_addr[0] ? data_i[7:0] : data_i[15:8];
          end
          if (rd_last) begin
            idx_q <= '0;
            st_q  <= S_WR1;
          end else begin
            idx_q <= idx_q + rd_step;
            st_q  <= S_RD1;
          end
        end
        S_WR1: st_q <= S_WR2;
        S_WR2: begin
          if (wr_last) begin
            idx_q <= '0;
            src_q <= src_q + AW'(nb);
            dst_q <= dst_q + AW'(nb);
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) st_q <= S_IDLE;
            else begin
              st_q  <= S_WAIT;
              gap_q <= GW'(MIN_IDLE);
            end
          end else begin
            idx_q <= idx_q + wr_step;
            st_q  <= S_WR1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R3: address held for both states, strobe in the second
  a_r3_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RD1) |=> (rd_o && $stable(addr_o)));
  a_r3_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WR1) |=> ((wr_hi_o || wr_lo_o) && $stable(addr_o)));
  // R5: lanes follow address parity
  a_r5_hi_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_o |-> !addr_o[0]);
  a_r5_lo_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_o && !wr_hi_o) |-> addr_o[0]);
  // R2: never read and write at once
  a_r2_one_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && (wr_hi_o || wr_lo_o)));
  // R7: strobes only while the bus is requested
  a_r7_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_hi_o || wr_lo_o) |-> bus_req_o);
  // R8: a release between units lasts more than one clock
  a_r8_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_req_o) && st_q == S_WAIT) |=> !bus_req_o);
  // R9: flag only inside owned cycles
  a_r9_tend_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tend_o |-> bus_req_o);
endmodule

// File: tb/dma_steal_chan_test.sv
`timescale 1ns/1ps
module dma_steal_chan_test;
  localparam int AW = 16;
  localparam int MIN_IDLE = 2;
  localparam int UNITS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] ra = '0;
  logic [31:0] wd = '0;
  logic gnt_en = 1'b0;
  logic bus_req, bus_gnt, rd, wr_hi, wr_lo, tend;
  logic [AW-1:0] addr;
  logic [15:0] rdata, wdata;
  logic [7:0] mem [0:255];

  int errors = 0, checks = 0;
  int rd_acc, wr_acc, wbytes, low_run, cur_sz, tend_hits;
  bit mon_on, expect_drop, in_gap, cur_tend, prev_strobe;
  logic [AW-1:0] prev_addr;

  always #2.5 clk = ~clk;

  assign bus_gnt = bus_req && gnt_en;
  assign rdata = {mem[{addr[7:1], 1'b0}], mem[{addr[7:1], 1'b1}]};

  dma_steal_chan #(.AW(AW), .CW(16), .MIN_IDLE(MIN_IDLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd),
    .bus_gnt_i(bus_gnt), .bus_req_o(bus_req), .addr_o(addr), .rd_o(rd),
    .wr_hi_o(wr_hi), .wr_lo_o(wr_lo), .data_i(rdata), .data_o(wdata), .tend_o(tend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int accesses(input int base, input int n);
    int c = 0;
    for (int u = 0; u < UNITS; u++) begin
      int i = 0;
      while (i < n) begin
        int a = base + u * n + i;
        if ((a % 2) == 0 && (n - i) >= 2) i += 2; else i += 1;
        c++;
      end
    end
    return c;
  endfunction

  // bus monitor and memory model, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      bit strobe;
      int unit_now;
      strobe = rd || wr_hi || wr_lo;
      if (expect_drop) begin
        chk(!bus_req, "R7 drop after last write", int'(bus_req), 0);
        expect_drop = 0; in_gap = 1; low_run = 0;
      end
      if (!bus_req) low_run++;
      else begin
        if (in_gap) chk(low_run >= MIN_IDLE, "R8 idle gap", low_run, MIN_IDLE);
        in_gap = 0;
      end
      if (strobe) begin
        chk(prev_addr == addr && !prev_strobe, "R3 two-state access", int'(addr), int'(prev_addr));
        unit_now = wbytes / cur_sz;
        chk(tend == (cur_tend && unit_now == UNITS - 1), "R9 tend", int'(tend),
            int'(cur_tend && unit_now == UNITS - 1));
        if (tend) tend_hits++;
      end
      if (rd) rd_acc++;
      if (wr_hi || wr_lo) begin
        wr_acc++;
        if (wr_hi) begin
          chk(!addr[0], "R5 upper lane even", int'(addr[0]), 0);
          mem[addr[7:0]] = wdata[15:8];
        end
        if (wr_lo && !wr_hi) chk(addr[0], "R5 lower lane odd", int'(addr[0]), 1);
        if (wr_lo) mem[{addr[7:1], 1'b1}] = wdata[7:0];
        wbytes += int'(wr_hi) + int'(wr_lo);
        if (wbytes % cur_sz == 0) expect_drop = 1;
      end
      prev_addr = addr;
      prev_strobe = strobe;
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; ra = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run(input int sz_code, input int so, input int doff, input bit te);
    int n, src, dst, total, t;
    logic [7:0] ref_mem [0:255];
    n = (sz_code == 0) ? 1 : (sz_code == 1) ? 2 : 4;
    src = 16 + so; dst = 128 + doff; total = n * UNITS;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + sz_code * 11 + so * 5 + doff);
      ref_mem[i] = mem[i];
    end
    rd_acc = 0; wr_acc = 0; wbytes = 0; low_run = 0; tend_hits = 0;
    cur_sz = n; cur_tend = te; expect_drop = 0; in_gap = 0; prev_strobe = 0;
    gnt_en = 1'b0;
    reg_wr(2'd0, 32'(src));
    reg_wr(2'd1, 32'(dst));
    reg_wr(2'd2, 32'(UNITS));
    mon_on = 1;
    reg_wr(2'd3, {28'd0, te, 2'(sz_code), 1'b1});
    chk(bus_req, "R7 request after start", int'(bus_req), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(bus_req && !rd, "R7 wait for grant", int'(rd), 0);
    end
    gnt_en = 1'b1;
    // R1: writes during an active transfer have no effect
    reg_wr(2'd0, 32'h0000_0040);
    reg_wr(2'd2, 32'd0);
    reg_wr(2'd3, 32'h0000_0001);
    t = 0;
    while ((wbytes < total || bus_req) && t < 2000) begin
      @(negedge clk); t++;
    end
    chk(t < 2000, "R6 transfer completes", t, 0);
    repeat (6) @(negedge clk);
    chk(!bus_req && wbytes == total, "R6 stops after count units", wbytes, total);
    mon_on = 0;
    for (int i = 0; i < total; i++)
      chk(mem[dst + i] == ref_mem[src + i], "R2 copied byte", int'(mem[dst + i]), int'(ref_mem[src + i]));
    chk(mem[dst - 1] == ref_mem[dst - 1], "R6 byte below untouched", int'(mem[dst - 1]), int'(ref_mem[dst - 1]));
    chk(mem[dst + total] == ref_mem[dst + total], "R6 byte above untouched",
        int'(mem[dst + total]), int'(ref_mem[dst + total]));
    chk(rd_acc == accesses(src, n), "R4 read access count", rd_acc, accesses(src, n));
    chk(wr_acc == accesses(dst, n), "R4 write access count", wr_acc, accesses(dst, n));
    chk((tend_hits > 0) == te, "R9 tend seen", tend_hits, int'(te));
  endtask

  initial begin
    mon_on = 0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !rd && !wr_hi && !wr_lo && !tend, "reset outputs idle",
        int'({bus_req, rd, wr_hi, wr_lo, tend}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 3; s++)
      for (int so = 0; so < 4; so++)
        for (int d = 0; d < 4; d++)
          run(s, so, d, bit'((so + d + s) % 2));
    // R6: zero count start does nothing
    reg_wr(2'd2, 32'd0);
    reg_wr(2'd3, 32'h0000_0005);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!bus_req && !rd, "R6 zero count idle", int'(bus_req), 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule